// File: doc/BRIEF.md
# Condition Code Register Update Unit

This block keeps a four-bit condition code register (link, fault, minus and value) for a microcoded processor datapath. On each clock edge where the load strobe is high, every bit takes a new value chosen by its own small selector. An update field from the microword constant drives these selectors. The sources are the ALU flags register, the upper bits of the result register and three bits from the ALU shift path.

Each flag follows its own encoded policy. A code can keep the bit, set it, clear it, invert it, or load it from a flag, a result-register bit or a shift-path bit. For the link and fault bits, some codes force a zero by disabling the selector. A byte-wide read path shows the condition codes in the upper nibble and the sense-switch inputs in the lower nibble.

Top module: `ccr_unit`

## Requirements
- R1: While `rst_n` is low, `ccr_q` is 0. It is still 0 after reset is released and before any load.
- R2: `ccr_q` changes only at a rising clock edge where `ccr_ld` is high. On any other edge it holds, whatever the other inputs do.
- R3: `upd_fld[1:0]` selects the minus (`ccr_q[1]`) and value (`ccr_q[0]`) update. Code 0 keeps both bits. Code 1 loads `fl_sign` and `fl_zero`. Code 2 loads `res_hi[3]` (result bit 7) into minus and `res_hi[2]` (result bit 6) into value. Code 3 loads `fl_sign16` and `fl_zero16`.
- R4: `upd_fld[4:2]` selects the fault (`ccr_q[2]`) update. Code 0 loads `res_hi[1]` (result bit 5). Code 1 sets the bit. Code 2 keeps it. Code 3 loads `fl_ovf`.
- R5: Fault codes 4 to 7 clear the fault bit.
- R6: `upd_fld[8:5]` selects the link (`ccr_q[3]`) update. Only the even codes load a value: 0 keeps the bit, 2 inverts it, 4 loads `fl_carry`, 6 sets it, 8 loads `res_hi[0]` (result bit 4), 10 loads `sh_ram7`, 12 loads `sh_ram0` and 14 loads `sh_q0`.
- R7: Any odd link code clears the link bit.
- R8: `rd_byte[7:4]` equals `ccr_q` (link, fault, minus, value from bit 7 down to bit 4). `rd_byte[3:0]` equals `sense[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ccr_ld | input | 1 | Load strobe for the condition codes |
| upd_fld | input | 9 | Update field: link[8:5], fault[4:2], minus/value[1:0] |
| fl_carry | input | 1 | ALU flag carry |
| fl_ovf | input | 1 | ALU flag overflow |
| fl_zero | input | 1 | ALU flag zero |
| fl_sign | input | 1 | ALU flag sign |
| fl_zero16 | input | 1 | ALU 16-bit zero flag |
| fl_sign16 | input | 1 | ALU 16-bit sign flag |
| res_hi | input | 4 | Result register bits 7 to 4 |
| sh_ram7 | input | 1 | ALU shift path RAM7 bit |
| sh_ram0 | input | 1 | ALU shift path RAM0 bit |
| sh_q0 | input | 1 | ALU shift path Q0 bit |
| sense | input | SENSE_W (4) | Sense switch inputs |
| ccr_q | output | 4 | Condition codes {link, fault, minus, value} |
| rd_byte | output | 4+SENSE_W (8) | Read byte {ccr_q, sense} |

## Verification
A load takes effect at the rising edge where `ccr_ld` is sampled high, so the new `ccr_q` and the upper nibble of `rd_byte` are due one edge after the stimulus. The lower nibble of `rd_byte` follows `sense` within the same cycle. The driver applies each stimulus at the falling edge and queues the expected result. The monitor pops that result shortly after the next rising edge and compares it there, well before the driver's next falling-edge change. Transactions with the strobe low queue the unchanged register value, which checks that the register holds.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   // update field layout
   localparam int VM_LSB   = 0;
   localparam int VM_W     = 2;
   localparam int FLT_LSB  = 2;
   localparam int FLT_W    = 3;
   localparam int LNK_LSB  = 5;
   localparam int LNK_W    = 4;
   localparam int UPD_W    = VM_W + FLT_W + LNK_W;
   localparam int CC_W     = 4;

   // minus/value codes
   localparam logic [1:0] VM_KEEP = 2'd0;
   localparam logic [1:0] VM_ALU  = 2'd1;
   localparam logic [1:0] VM_RES  = 2'd2;
   localparam logic [1:0] VM_W16  = 2'd3;

   // fault codes (bit 2 set clears)
   localparam logic [2:0] FT_RES  = 3'd0;
   localparam logic [2:0] FT_SET  = 3'd1;
   localparam logic [2:0] FT_KEEP = 3'd2;
   localparam logic [2:0] FT_OVF  = 3'd3;

   typedef struct packed {
      logic link;
      logic fault;
      logic minus;
      logic value;
   } ccr_t;
endpackage

// File: rtl/ccr_vm_sel.sv
module ccr_vm_sel
   import ccr_pkg::*;
(
   input  logic [1:0] code,
   input  logic       old_minus,
   input  logic       old_value,
   input  logic       fl_zero,
   input  logic       fl_sign,
   input  logic       fl_zero16,
   input  logic       fl_sign16,
   input  logic       res7,
   input  logic       res6,
   output logic       nxt_minus,
   output logic       nxt_value
);
   always_comb begin
      unique case (code)
         VM_KEEP: begin nxt_minus = old_minus; nxt_value = old_value; end
         VM_ALU:  begin nxt_minus = fl_sign;   nxt_value = fl_zero;   end
         VM_RES:  begin nxt_minus = res7;      nxt_value = res6;      end
         default: begin nxt_minus = fl_sign16; nxt_value = fl_zero16; end
      endcase
   end
endmodule

// File: rtl/ccr_fault_sel.sv
module ccr_fault_sel
   import ccr_pkg::*;
(
   input  logic [2:0] code,
   input  logic       old_fault,
   input  logic       res5,
   input  logic       fl_ovf,
   output logic       nxt_fault
);
   logic sel_out;
   always_comb begin
      unique case (code[1:0])
         FT_RES[1:0]:  sel_out = res5;
         FT_SET[1:0]:  sel_out = 1'b1;
         FT_KEEP[1:0]: sel_out = old_fault;
         default:      sel_out = fl_ovf;
      endcase
      // top code bit disables the selector, forcing zero
      nxt_fault = sel_out & ~code[2];
   end
endmodule

// File: rtl/ccr_link_sel.sv
module ccr_link_sel
   import ccr_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic [SEL_W:0] code,
   input  logic           old_link,
   input  logic           fl_carry,
   input  logic           res4,
   input  logic           sh_ram7,
   input  logic           sh_ram0,
   input  logic           sh_q0,
   output logic           nxt_link
);
   localparam int NCAND = 1 << SEL_W;

   logic [NCAND-1:0] cand;
   logic [SEL_W-1:0] sel;
   logic             en;

   generate
      if (NCAND == 8) begin : g_std
         assign cand = {sh_q0, sh_ram0, sh_ram7, res4,
                        1'b1, fl_carry, ~old_link, old_link};
      end else begin : g_bad
         assign cand = '0;
      end
   endgenerate

   assign sel = code[SEL_W:1];
   assign en  = ~code[0];   // odd code disables the selector

   always_comb nxt_link = en & cand[sel];

   initial begin
      assert (SEL_W == 3)
         else $error("ccr_link_sel: SEL_W must be 3");
   end
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
   import ccr_pkg::*;
#(
   parameter int SENSE_W = 4,
   localparam int RD_W   = CC_W + SENSE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ccr_ld,
   input  logic [UPD_W-1:0]   upd_fld,
   input  logic               fl_carry,
   input  logic               fl_ovf,
   input  logic               fl_zero,
   input  logic               fl_sign,
   input  logic               fl_zero16,
   input  logic               fl_sign16,
   input  logic [3:0]         res_hi,
   input  logic               sh_ram7,
   input  logic               sh_ram0,
   input  logic               sh_q0,
   input  logic [SENSE_W-1:0] sense,
   output logic [CC_W-1:0]    ccr_q,
   output logic [RD_W-1:0]    rd_byte
);
   ccr_t cc_r, cc_n;

   ccr_vm_sel u_vm (
      .code      (upd_fld[VM_LSB +: VM_W]),
      .old_minus (cc_r.minus),
      .old_value (cc_r.value),
      .fl_zero   (fl_zero),
      .fl_sign   (fl_sign),
      .fl_zero16 (fl_zero16),
      .fl_sign16 (fl_sign16),
      .res7      (res_hi[3]),
      .res6      (res_hi[2]),
      .nxt_minus (cc_n.minus),
      .nxt_value (cc_n.value)
   );

   ccr_fault_sel u_flt (
      .code      (upd_fld[FLT_LSB +: FLT_W]),
      .old_fault (cc_r.fault),
      .res5      (res_hi[1]),
      .fl_ovf    (fl_ovf),
      .nxt_fault (cc_n.fault)
   );

   ccr_link_sel #(.SEL_W(LNK_W-1)) u_lnk (
      .code      (upd_fld[LNK_LSB +: LNK_W]),
      .old_link  (cc_r.link),
      .fl_carry  (fl_carry),
      .res4      (res_hi[0]),
      .sh_ram7   (sh_ram7),
      .sh_ram0   (sh_ram0),
      .sh_q0     (sh_q0),
      .nxt_link  (cc_n.link)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cc_r <= '0;
      else if (ccr_ld) cc_r <= cc_n;
   end

   assign ccr_q   = cc_r;
   assign rd_byte = {cc_r, sense};

   initial begin
      assert (SENSE_W >= 1)
         else $error("ccr_unit: SENSE_W must be at least 1");
   end

   // R2: no strobe, no change
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ccr_ld |=> $stable(ccr_q));

   // R3: keep code leaves minus/value alone
   assert_vm_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_ld && upd_fld[1:0] == VM_KEEP) |=> ccr_q[1:0] == $past(ccr_q[1:0]));

   // R4: set code forces fault high
   assert_fault_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_ld && upd_fld[4:2] == FT_SET) |=> ccr_q[2]);

   // R5: high fault codes clear
   assert_fault_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_ld && upd_fld[4]) |=> !ccr_q[2]);

   // R6: invert code flips link
   assert_link_inv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_ld && upd_fld[8:5] == 4'd2) |=> ccr_q[3] != $past(ccr_q[3]));

   // R7: odd link code clears
   assert_link_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_ld && upd_fld[5]) |=> !ccr_q[3]);
endmodule

// File: tb/sim_ccr_unit.sv
module sim_ccr_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ccr_ld = 1'b0;
   logic [8:0] upd_fld = '0;
   logic       fl_carry = 0, fl_ovf = 0, fl_zero = 0, fl_sign = 0;
   logic       fl_zero16 = 0, fl_sign16 = 0;
   logic [3:0] res_hi = '0;
   logic       sh_ram7 = 0, sh_ram0 = 0, sh_q0 = 0;
   logic [3:0] sense = '0;
   logic [3:0] ccr_q;
   logic [7:0] rd_byte;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   typedef struct {
      logic [3:0] cc;
      logic [3:0] sw;
      bit         ld;
      logic [8:0] fld;
   } exp_t;
   exp_t sb[$];

   logic [3:0] model = '0;

   always #4 clk = ~clk;   // 125 MHz

   ccr_unit u0 (
      .clk(clk), .rst_n(rst_n), .ccr_ld(ccr_ld), .upd_fld(upd_fld),
      .fl_carry(fl_carry), .fl_ovf(fl_ovf), .fl_zero(fl_zero),
      .fl_sign(fl_sign), .fl_zero16(fl_zero16), .fl_sign16(fl_sign16),
      .res_hi(res_hi), .sh_ram7(sh_ram7), .sh_ram0(sh_ram0),
      .sh_q0(sh_q0), .sense(sense), .ccr_q(ccr_q), .rd_byte(rd_byte)
   );

   task automatic chk(input string req, input logic [7:0] act,
                      input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] next_cc(input logic [3:0] cur,
                                          input logic [8:0] f);
      logic [3:0] n;
      case (f[1:0])
         2'd0: n[1:0] = cur[1:0];
         2'd1: n[1:0] = {fl_sign, fl_zero};
         2'd2: n[1:0] = {res_hi[3], res_hi[2]};
         default: n[1:0] = {fl_sign16, fl_zero16};
      endcase
      case (f[4:2])
         3'd0: n[2] = res_hi[1];
         3'd1: n[2] = 1'b1;
         3'd2: n[2] = cur[2];
         3'd3: n[2] = fl_ovf;
         default: n[2] = 1'b0;
      endcase
      case (f[8:5])
         4'd0:  n[3] = cur[3];
         4'd2:  n[3] = ~cur[3];
         4'd4:  n[3] = fl_carry;
         4'd6:  n[3] = 1'b1;
         4'd8:  n[3] = res_hi[0];
         4'd10: n[3] = sh_ram7;
         4'd12: n[3] = sh_ram0;
         4'd14: n[3] = sh_q0;
         default: n[3] = 1'b0;
      endcase
      return n;
   endfunction

   // driver: apply at falling edge, queue expectation for next rising edge
   task automatic drive(input bit ld, input logic [8:0] f,
                        input logic [15:0] pat);
      @(negedge clk);
      ccr_ld = ld;
      upd_fld = f;
      {fl_carry, fl_ovf, fl_zero, fl_sign, fl_zero16, fl_sign16} = pat[5:0];
      res_hi = pat[9:6];
      {sh_ram7, sh_ram0, sh_q0} = pat[12:10];
      sense = pat[15:12];
      if (ld) model = next_cc(model, f);
      sb.push_back('{cc: model, sw: sense, ld: ld, fld: f});
   endtask

   // monitor: compare shortly after each rising edge
   always @(posedge clk) begin
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         #2;
         e = sb.pop_front();
         if (!e.ld) chk("R2 hold", {4'h0, ccr_q}, {4'h0, e.cc});
         else begin
            chk("R3 minus/value", {6'h0, ccr_q[1:0]}, {6'h0, e.cc[1:0]});
            chk(e.fld[4] ? "R5 fault clear" : "R4 fault",
                {7'h0, ccr_q[2]}, {7'h0, e.cc[2]});
            chk(e.fld[5] ? "R7 link clear" : "R6 link",
                {7'h0, ccr_q[3]}, {7'h0, e.cc[3]});
         end
         chk("R8 read byte", rd_byte, {e.cc, e.sw});
      end
   end

   initial begin
      fork
         begin
            sense = 4'hA;
            #3;
            chk("R1 in reset", {4'h0, ccr_q}, 8'h00);
            repeat (3) @(posedge clk);
            @(negedge clk);
            rst_n = 1'b1;
            #1;
            chk("R1 after reset", {4'h0, ccr_q}, 8'h00);
            chk("R8 read after reset", rd_byte, 8'h0A);
            // directed: set then invert twice (R6), then odd code (R7)
            drive(1, {4'd6, 3'd1, 2'd0}, 16'h0000);
            drive(1, {4'd2, 3'd2, 2'd0}, 16'h0000);
            drive(1, {4'd2, 3'd2, 2'd0}, 16'hFFFF);
            drive(1, {4'd7, 3'd5, 2'd0}, 16'hFFFF);
            // hold with all inputs toggling (R2)
            drive(1, {4'd6, 3'd1, 2'd3}, 16'hFFFF);
            drive(0, {4'd9, 3'd4, 2'd1}, 16'h0000);
            drive(0, {4'd1, 3'd7, 2'd2}, 16'h5A5A);
            // sweep every update code under varied patterns
            for (int i = 0; i < 1024; i++) begin
               logic [15:0] p;
               p = 16'(i * 16'h9E37) ^ 16'(i >> 3);
               drive((i % 7) != 3, 9'(i), p);
            end
            @(negedge clk);
            ccr_ld = 1'b0;
            repeat (3) @(posedge clk);
            #3;
         end
         begin
            while (cycles < 20000) begin
               @(posedge clk);
               cycles++;
            end
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule